// File: doc/BRIEF.md
# Flash Operation Status Byte Generator

This block forms the byte a host sees when it reads a flash device while an embedded program or erase is in progress, after such an operation has failed, or while an erase is suspended. The controller that runs the algorithm feeds it the kind of operation, whether the erase has actually begun, whether it is suspended, whether it has failed, and bit 7 of the value being written. Two per-block masks are also supplied: one marks blocks chosen for erasure, the other marks blocks whose erase failed. The block turns these into polling, toggle, error and phase bits. When a read should see stored data instead, it passes the array byte through.

Two toggle flip-flops live inside the block and advance on reads. The first advances on every status read while the operation is not suspended, whatever the address. The second advances only when the address falls in the region of interest. That region is normally the set of blocks chosen for erasure. After a failed erase it narrows to the blocks that failed. A host can therefore poll any address for progress, and then poll per block to find the blocks being erased or the ones that failed.

The read result is registered. A strobe sampled on one clock edge yields `rd_data` after that edge, and `rd_data` holds until the next strobe.

Top module: `flash_status_gen`

## Requirements
- R1: With `op_kind` = 2'b01 (program) and not suspended, a status read returns bit 7 as the inverse of `prog_bit7`.
- R2: With `op_kind` = 2'b10 (chip erase) or 2'b11 (block erase) and not suspended, bit 7 of a status read is 0. While `suspended` is high, a status read returns 1 on bit 7.
- R3: Bit 6 holds the first toggle flip-flop. It inverts after every status read taken while not suspended, at any address.
- R4: While `suspended` is high, the first toggle flip-flop does not change, so bit 6 repeats its last value.
- R5: Bit 5 of a status read equals `op_err`. The controller holds `op_err` until a reset command clears it.
- R6: Bit 3 reads 0 for a program and 1 for a chip erase. For a block erase it reads `erase_started`: 0 while extra blocks are still being collected, 1 once the erase runs.
- R7: Bit 2 holds the second toggle flip-flop. It inverts after a status read whose address lies in a block flagged in `erase_sel`, during suspend as well, and holds for reads elsewhere. With `NUM_BLOCKS` equal-sized blocks, block i covers addresses i*2^ADDR_W/NUM_BLOCKS up to the next block base.
- R8: While `op_err` is high during an erase kind, the second toggle flip-flop advances only on reads from blocks flagged in `erase_fail`.
- R9: A read returns `array_data` unchanged when no status is due. This is the case while suspended outside the chosen blocks without an error, and also with `op_active` and `op_err` both low.
- R10: A pulse on `op_start` clears both toggle flip-flops, so the first status read of each operation returns 0 on bits 6 and 2.
- R11: Bits 4, 1 and 0 of every status read are 0. `busy` equals `op_active`. After reset `rd_data` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse when a new program or erase begins |
| op_kind | input | 2 | 00 none, 01 program, 10 chip erase, 11 block erase |
| op_active | input | 1 | Controller is running an operation |
| erase_started | input | 1 | Block erase has left its collection window |
| suspended | input | 1 | Erase is suspended |
| op_err | input | 1 | Operation failed; held until cleared by a reset command |
| prog_bit7 | input | 1 | Bit 7 of the value being programmed |
| erase_sel | input | NUM_BLOCKS | Blocks chosen for erasure |
| erase_fail | input | NUM_BLOCKS | Blocks whose erase failed |
| rd_addr | input | ADDR_W | Read address |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| array_data | input | 8 | Stored byte at `rd_addr` |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | Operation in progress |

## Verification
The assertions take it for granted that the controller asserts `op_start` only while no read is being strobed. They also assume `op_kind`, the masks and the flags stay steady for the cycle in which `rd_stb` is sampled, and that the masks describe real blocks: during a program no block is flagged as chosen for erasure. The stimulus changes inputs only on falling edges, issues `op_start` in its own cycle ahead of any read, and keeps program-phase reads in an unchosen block. It then walks through suspend, failure and idle phases with fixed masks, so every expected byte follows from the toggle history the bench tracks.

// File: rtl/flash_status_pkg.sv
// Package: shared operation encoding and status byte bit positions.
// Assumes: the controller drives op_kind with the values below.
package flash_status_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_CHIP  = 2'b10,
        OP_BLOCK = 2'b11
    } op_kind_e;

    localparam int POS_POLL    = 7;
    localparam int POS_TGL_ANY = 6;
    localparam int POS_FAIL    = 5;
    localparam int POS_PHASE   = 3;
    localparam int POS_TGL_RGN = 2;

endpackage

// File: rtl/fsg_block_match.sv
// Module: fsg_block_match
// Finds which equal-sized block an address lies in and reports whether that
// block is flagged in the chosen-for-erase and failed-erase masks.
// Assumes: NUM_BLOCKS divides 2**ADDR_W evenly.
module fsg_block_match #(
    parameter int NUM_BLOCKS = 8,
    parameter int ADDR_W     = 12
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_BLOCKS-1:0] sel_mask,
    input  logic [NUM_BLOCKS-1:0] fail_mask,
    output logic                  in_sel,
    output logic                  in_fail
);
    localparam int SPAN = (1 << ADDR_W) / NUM_BLOCKS;

    logic [NUM_BLOCKS-1:0] hit;

    // One range comparator per block.
    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_range
        localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(i * SPAN);
        localparam logic [ADDR_W:0] HI = (ADDR_W+1)'((i + 1) * SPAN);
        assign hit[i] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    end

    // Reduce the hit vector against each mask.
    always_comb begin
        in_sel  = |(hit & sel_mask);
        in_fail = |(hit & fail_mask);
    end

endmodule

// File: rtl/fsg_toggle_pair.sv
// Module: fsg_toggle_pair
// Holds the two toggle flip-flops. The any-address toggle advances on each
// status read outside suspend. The region toggle advances on each status read
// whose address is in the active region.
// Assumes: op_start and a status read never coincide; start wins if they do.
module fsg_toggle_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic stat_rd,
    input  logic suspended,
    input  logic in_region,
    output logic tgl_any,
    output logic tgl_rgn
);
    // Advance or clear both toggles.
    always_ff @(posedge clk) begin
        if (!rst_n || op_start) begin
            tgl_any <= 1'b0;
            tgl_rgn <= 1'b0;
        end else if (stat_rd) begin
            if (!suspended) tgl_any <= ~tgl_any;
            if (in_region)  tgl_rgn <= ~tgl_rgn;
        end
    end

    AST_ANY_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !suspended && !op_start |=> tgl_any != $past(tgl_any)); // R3
    AST_ANY_FROZEN_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && !op_start |=> $stable(tgl_any)); // R4
    AST_RGN_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_region && !op_start |=> $stable(tgl_rgn)); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !tgl_any && !tgl_rgn); // R10

endmodule

// File: rtl/fsg_byte_build.sv
// Module: fsg_byte_build
// Assembles the status byte from operation kind, phase, error and toggles.
// Assumes: inputs are steady in the cycle the read is captured.
module fsg_byte_build
    import flash_status_pkg::*;
(
    input  op_kind_e    kind,
    input  logic        suspended,
    input  logic        err,
    input  logic        erase_started,
    input  logic        prog_bit7,
    input  logic        tgl_any,
    input  logic        tgl_rgn,
    output logic [7:0]  status
);
    // Combine the fields; unused positions stay 0.
    always_comb begin
        status = 8'h00;
        if (suspended)            status[POS_POLL] = 1'b1;
        else if (kind == OP_PROG) status[POS_POLL] = ~prog_bit7;
        else                      status[POS_POLL] = 1'b0;
        status[POS_TGL_ANY] = tgl_any;
        status[POS_FAIL]    = err;
        unique case (kind)
            OP_CHIP:  status[POS_PHASE] = 1'b1;
            OP_BLOCK: status[POS_PHASE] = erase_started;
            default:  status[POS_PHASE] = 1'b0;
        endcase
        status[POS_TGL_RGN] = tgl_rgn;
    end

endmodule

// File: rtl/flash_status_gen.sv
// Module: flash_status_gen (top)
// Decides whether a read returns status or array data, keeps the toggles and
// registers the read result. busy mirrors the controller's activity flag.
// Assumes: op_start is a single-cycle pulse issued apart from read strobes.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_start,
    input  logic [1:0]            op_kind,
    input  logic                  op_active,
    input  logic                  erase_started,
    input  logic                  suspended,
    input  logic                  op_err,
    input  logic                  prog_bit7,
    input  logic [NUM_BLOCKS-1:0] erase_sel,
    input  logic [NUM_BLOCKS-1:0] erase_fail,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_stb,
    input  logic [7:0]            array_data,
    output logic [7:0]            rd_data,
    output logic                  busy
);
    op_kind_e   kind;
    logic       in_sel, in_fail, in_region, status_mode, stat_rd;
    logic       tgl_any, tgl_rgn;
    logic [7:0] status;

    assign kind = op_kind_e'(op_kind);
    assign busy = op_active;

    fsg_block_match #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_match (
        .addr      (rd_addr),
        .sel_mask  (erase_sel),
        .fail_mask (erase_fail),
        .in_sel    (in_sel),
        .in_fail   (in_fail)
    );

    // Pick the toggle region and decide whether this read shows status.
    always_comb begin
        in_region   = (op_err && (kind == OP_CHIP || kind == OP_BLOCK)) ? in_fail : in_sel;
        status_mode = op_err || (op_active && !suspended) || (suspended && in_sel);
        stat_rd     = rd_stb && status_mode;
    end

    fsg_toggle_pair u_tgl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .stat_rd   (stat_rd),
        .suspended (suspended),
        .in_region (in_region),
        .tgl_any   (tgl_any),
        .tgl_rgn   (tgl_rgn)
    );

    fsg_byte_build u_build (
        .kind          (kind),
        .suspended     (suspended),
        .err           (op_err),
        .erase_started (erase_started),
        .prog_bit7     (prog_bit7),
        .tgl_any       (tgl_any),
        .tgl_rgn       (tgl_rgn),
        .status        (status)
    );

    // Capture the read result on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= 8'h00;
        else if (rd_stb) rd_data <= status_mode ? status : array_data;
    end

    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !status_mode |=> rd_data == $past(array_data)); // R9
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && status_mode |=> rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00); // R11
    AST_FAIL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && status_mode |=> rd_data[POS_FAIL] == $past(op_err)); // R5
    AST_SUSP_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && status_mode && suspended |=> rd_data[POS_POLL]); // R2
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && status_mode && !suspended && op_kind == 2'b01
        |=> rd_data[POS_POLL] == !$past(prog_bit7)); // R1

endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;

    localparam int NB = 8;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_start, op_active, erase_started, suspended, op_err, prog_bit7, rd_stb;
    logic [1:0]    op_kind;
    logic [NB-1:0] erase_sel, erase_fail;
    logic [AW-1:0] rd_addr;
    logic [7:0]    array_data, rd_data;
    logic          busy;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    flash_status_gen #(.NUM_BLOCKS(NB), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_active(op_active), .erase_started(erase_started), .suspended(suspended),
        .op_err(op_err), .prog_bit7(prog_bit7), .erase_sel(erase_sel),
        .erase_fail(erase_fail), .rd_addr(rd_addr), .rd_stb(rd_stb),
        .array_data(array_data), .rd_data(rd_data), .busy(busy)
    );

    // start, kind, active, susp, err, started, pbit, addr, array, expected
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 8'h5A, 8'h00}, // R1 R10
        {1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h1FF, 8'h5A, 8'hC0}, // R1 R3
        {1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h200, 8'h5A, 8'h08}, // R2 R6 R10
        {1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'hE00, 8'h5A, 8'h4C}, // R3 R7
        {1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h400, 8'h5A, 8'h00}, // R6
        {1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'h300, 8'h5A, 8'h4C}, // R6 R7
        {1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 12'h300, 8'h5A, 8'h88}, // R2 R4
        {1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 12'h400, 8'h5A, 8'h8C}, // R4 R7
        {1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 12'h000, 8'h5A, 8'h5A}, // R9
        {1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 12'h200, 8'h5A, 8'h28}, // R5 R8
        {1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 12'h400, 8'h5A, 8'h68}, // R8
        {1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 12'h400, 8'h5A, 8'h2C}, // R8 R11
        {1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h400, 8'hA5, 8'hA5}  // R9
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_start = 1'b0; op_kind = 2'b00; op_active = 1'b0;
        erase_started = 1'b0; suspended = 1'b0; op_err = 1'b0; prog_bit7 = 1'b0;
        erase_sel = 8'b0000_0110; erase_fail = 8'b0000_0100;
        rd_addr = '0; rd_stb = 1'b0; array_data = 8'h00;
        repeat (3) @(negedge clk);
        check("R11 reset rd_data", rd_data, 8'h00);
        check("R11 reset busy", {7'b0, busy}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            v = VEC[i];
            op_kind = v[34:33]; op_active = v[32]; suspended = v[31];
            op_err = v[30]; erase_started = v[29]; prog_bit7 = v[28];
            rd_addr = v[27:16]; array_data = v[15:8];
            if (v[35]) pulse_start();
            do_read();
            check($sformatf("R1-table vector %0d (R2 R3 R4 R5 R6 R7 R8 R9)", i), rd_data, v[7:0]);
        end

        // busy follows op_active
        op_active = 1'b1;
        @(negedge clk);
        check("R11 busy high", {7'b0, busy}, 8'h01);
        op_active = 1'b0;
        @(negedge clk);
        check("R11 busy low", {7'b0, busy}, 8'h00);

        // Back-to-back strobes after a chip erase start, in a chosen block
        op_kind = 2'b10; op_active = 1'b1; op_err = 1'b0; suspended = 1'b0;
        rd_addr = 12'h200; array_data = 8'h33;
        pulse_start();
        rd_stb = 1'b1;
        @(negedge clk);
        check("R10 first read after start", rd_data, 8'h08);
        @(negedge clk);
        rd_stb = 1'b0;
        check("R3 R7 second back-to-back read", rd_data, 8'h4C);

        // No strobe: result holds
        rd_addr = 12'h000; array_data = 8'hFF;
        @(negedge clk);
        check("R11 hold without strobe", rd_data, 8'h4C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule